// File: doc/BRIEF.md
# Bitmap Access-Map Stride Prefetcher

This block observes the stream of demand data accesses into a cache, expressed as cache-line addresses, and proposes lines worth fetching ahead of use. Memory is cut into aligned 4 KiB regions of 64 lines of 64 bytes each. For each region it is tracking, the block holds a 64-bit map with one bit per line that says whether that line has been touched. It also holds a second map that says whether a prefetch for that line has already been handed out. The table has eight such region entries. It is fully associative and replaces the least recently used entry.

Each valid access marks its line in the map of its region. In the same cycle, a bank of matchers tests every stride from 1 to 31 lines, both upward and downward, against the updated map. No training period is needed: a stride is found as soon as the two lines behind the access at that stride are marked. The map stores no arrival order and no instruction address, so a given set of lines produces the same map whatever order the lines arrive in. Up to two of the candidate lines found are placed in a small request queue. The cache side drains the queue through a valid/ready handshake.

Top module: `bitmap_stride_prefetcher`

## Requirements
- R1: A synchronous active-high reset empties the request queue (pf_valid is low the cycle after reset) and invalidates every region entry, so maps recorded before the reset produce no candidates afterwards.
- R2: A line address splits into a region tag (all bits above the low 6) and a line index (the low 6 bits). Every valid access marks its line in its region's map in the cycle it is sampled, even while earlier requests are still waiting in the queue.
- R3: Upward match: for line index a and stride k in 1..31, line a+k is a candidate when lines a-k and a-2k are both marked. A region freshly allocated by the current access therefore yields no candidate.
- R4: Downward match: for stride k in 1..31, line a-k is a candidate when lines a+k and a+2k are both marked.
- R5: A candidate whose index falls outside 0..63 of its region is never produced.
- R6: A candidate whose line is already marked as accessed is suppressed.
- R7: When a request is accepted (pf_valid and pf_ready high at a clock edge), the issued bit of that line is set in its region entry if that entry is still present. While the entry stays present, the line is not requested again.
- R8: One access queues at most two requests. Candidates are taken in order of increasing stride, and the upward one comes first when both directions have the same stride.
- R9: Requests go through a 4-deep FIFO and leave in the order they were queued. A request appears on pf_line the cycle after its access is sampled. Candidates beyond the free space counted at the start of the cycle are dropped. pf_line stays stable while pf_valid is high and pf_ready is low.
- R10: The table holds 8 regions. A miss takes the lowest-numbered invalid entry, or else the least recently accessed entry, and starts it with both maps cleared. Accepting a request does not count as a use for recency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_line | input | 26 | Line address of the access (byte address bits 31:6) |
| pf_valid | output | 1 | A prefetch request is waiting at the queue head |
| pf_ready | input | 1 | The consumer takes the head request this cycle |
| pf_line | output | 26 | Line address of the head prefetch request |

## Verification
A corrupted bit in an access map or an issued map stays hidden until an access lands in the same region, at a stride that reaches the bad bit. That access then puts an extra request on pf_line, or leaves out an expected one, exactly one cycle later. Faults in recency or allocation show up only after a ninth distinct region forces a replacement: a region that should have been kept comes back with an empty map, or an evicted one still produces strides. A queue pointer or occupancy error shows at once as a wrong head line or a missing drop, so the bench compares the port-level queue contents every cycle against a model built from the rules above.

// File: rtl/bitmap_stride_prefetcher.sv
module bitmap_stride_prefetcher #(
  parameter int LINE_AW    = 26,
  parameter int IDX_W      = 6,
  parameter int ENTRIES    = 8,
  parameter int MAX_STRIDE = 31,
  parameter int PF_PER_ACC = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [LINE_AW-1:0] acc_line,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [LINE_AW-1:0] pf_line
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = LINE_AW - IDX_W;
  localparam int EW    = $clog2(ENTRIES);
  localparam int NCAND = 2 * MAX_STRIDE;
  localparam int FW    = $clog2(FIFO_DEPTH);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);
  localparam int PW    = $clog2(PF_PER_ACC + 1);

  typedef logic [LINES-1:0] map_t;

  logic [ENTRIES-1:0] v_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  map_t               acc_q [ENTRIES];
  map_t               iss_q [ENTRIES];
  logic [EW-1:0]      age_q [ENTRIES];
  logic [LINE_AW-1:0] fifo_q [FIFO_DEPTH];
  logic [FW-1:0]      rd_q, wr_q;
  logic [CW-1:0]      cnt_q;

  wire [TAG_W-1:0] a_tag = acc_line[LINE_AW-1:IDX_W];
  wire [IDX_W-1:0] a_idx = acc_line[IDX_W-1:0];

  assign pf_valid = (cnt_q != '0);
  assign pf_line  = fifo_q[rd_q];
  wire pop = pf_valid && pf_ready;
  wire [TAG_W-1:0] p_tag = pf_line[LINE_AW-1:IDX_W];
  wire map_t p_bit = map_t'(1) << pf_line[IDX_W-1:0];

  logic          hit, free_ok, p_hit, dup;
  logic [EW-1:0] hit_e, free_e, lru_e, p_e, tgt;
  map_t          cur_acc, cur_iss, new_map;

  always_comb begin
    hit = 1'b0; hit_e = '0; free_ok = 1'b0; free_e = '0;
    lru_e = '0; p_hit = 1'b0; p_e = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!v_q[e]) begin free_ok = 1'b1; free_e = EW'(e); end
    for (int e = 0; e < ENTRIES; e++) begin
      if (v_q[e] && tag_q[e] == a_tag) begin hit = 1'b1; hit_e = EW'(e); end
      if (v_q[e] && tag_q[e] == p_tag) begin p_hit = 1'b1; p_e = EW'(e); end
      if (age_q[e] == EW'(ENTRIES - 1)) lru_e = EW'(e);
    end
    tgt     = hit ? hit_e : (free_ok ? free_e : lru_e);
    cur_acc = hit ? acc_q[hit_e] : '0;
    cur_iss = hit ? iss_q[hit_e] : '0;
    new_map = cur_acc | (map_t'(1) << a_idx);
  end

  function automatic logic mark(map_t m, int i);
    return (i >= 0 && i < LINES) ? m[i[IDX_W-1:0]] : 1'b0;
  endfunction

  // even slot: upward stride k, odd slot: downward stride k, k = slot/2 + 1
  logic [NCAND-1:0] cand;
  always_comb begin
    for (int k = 1; k <= MAX_STRIDE; k++) begin
      cand[2*k-2] = (int'(a_idx) + k < LINES)
                  && mark(new_map, int'(a_idx) - k) && mark(new_map, int'(a_idx) - 2*k)
                  && !mark(new_map, int'(a_idx) + k) && !mark(cur_iss, int'(a_idx) + k);
      cand[2*k-1] = (int'(a_idx) - k >= 0)
                  && mark(new_map, int'(a_idx) + k) && mark(new_map, int'(a_idx) + 2*k)
                  && !mark(new_map, int'(a_idx) - k) && !mark(cur_iss, int'(a_idx) - k);
    end
  end

  logic [NCAND-1:0]      rem;
  logic [PF_PER_ACC-1:0] pk_v, push_en;
  logic [IDX_W-1:0]      pk_idx [PF_PER_ACC];
  logic [PW-1:0]         push_n;

  always_comb begin
    rem = cand;
    push_n = '0;
    for (int p = 0; p < PF_PER_ACC; p++) begin
      pk_v[p] = 1'b0;
      pk_idx[p] = '0;
      for (int s = 0; s < NCAND; s++)
        if (rem[s] && !pk_v[p]) begin
          pk_v[p] = 1'b1;
          pk_idx[p] = (s % 2 == 0) ? a_idx + IDX_W'(s / 2 + 1) : a_idx - IDX_W'(s / 2 + 1);
          rem[s] = 1'b0;
        end
      push_en[p] = acc_valid && pk_v[p] && (int'(cnt_q) + p < FIFO_DEPTH);
      if (push_en[p]) push_n = push_n + PW'(1);
    end
  end

  // FIFO_DEPTH is taken to be a power of two so the pointers wrap naturally
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else begin
      for (int p = 0; p < PF_PER_ACC; p++)
        if (push_en[p]) fifo_q[wr_q + FW'(p)] <= {a_tag, pk_idx[p]};
      wr_q  <= wr_q + FW'(push_n);
      rd_q  <= rd_q + FW'(pop);
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int e = 0; e < ENTRIES; e++) age_q[e] <= EW'(e);
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (acc_valid && tgt == EW'(e)) begin
          v_q[e]   <= 1'b1;
          tag_q[e] <= a_tag;
          acc_q[e] <= new_map;
          iss_q[e] <= cur_iss | ((pop && p_hit && hit && p_e == tgt) ? p_bit : '0);
          age_q[e] <= '0;
        end else begin
          if (pop && p_hit && p_e == EW'(e)) iss_q[e] <= iss_q[e] | p_bit;
          if (acc_valid && age_q[e] < age_q[tgt]) age_q[e] <= age_q[e] + EW'(1);
        end
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (v_q[i] && v_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
  end

  a_r1_flush: assert property (@(posedge clk) rst |=> !pf_valid);
  a_r9_depth: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(FIFO_DEPTH));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));
  a_r10_unique_tags: assert property (@(posedge clk) disable iff (rst) !dup);
  a_r3_fresh_region_silent: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !hit |-> pk_v == '0);
endmodule

// File: tb/bitmap_stride_prefetcher_tb.sv
module bitmap_stride_prefetcher_tb_top;
  localparam int CLK_NS = 10;
  localparam int LAW = 26, IW = 6, NE = 8, MS = 31, DEP = 4, TW = LAW - IW;

  logic clk = 1'b0, rst = 1'b1, acc_valid = 1'b0, pf_ready = 1'b0;
  logic [LAW-1:0] acc_line = '0;
  logic pf_valid;
  logic [LAW-1:0] pf_line;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS / 2) clk = ~clk;

  bitmap_stride_prefetcher dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_line(acc_line),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  bit             m_v   [NE];
  logic [TW-1:0]  m_tag [NE];
  logic [63:0]    m_acc [NE];
  logic [63:0]    m_iss [NE];
  int             m_age [NE];
  logic [LAW-1:0] m_q [$];

  function automatic bit mk(logic [63:0] m, int i);
    return (i >= 0 && i < 64) ? m[i[5:0]] : 1'b0;
  endfunction

  function automatic logic [LAW-1:0] ln(int t, int i);
    return {TW'(t), IW'(i)};
  endfunction

  task automatic model_reset();
    for (int e = 0; e < NE; e++) begin m_v[e] = 0; m_age[e] = e; end
    m_q.delete();
  endtask

  task automatic model_step();
    int sz0, ph, tgt, a, np;
    bit pop, alloc;
    logic [LAW-1:0] pl;
    logic [TW-1:0] tg;
    logic [63:0] ca, ci, nm;
    int pick [2];
    sz0 = m_q.size();
    pop = (sz0 > 0) && pf_ready;
    ph = -1; pl = '0; np = 0; alloc = 0; tgt = -1;
    if (pop) begin
      pl = m_q[0];
      for (int e = 0; e < NE; e++) if (m_v[e] && m_tag[e] == pl[LAW-1:IW]) ph = e;
    end
    if (acc_valid) begin
      tg = acc_line[LAW-1:IW];
      a = int'(acc_line[IW-1:0]);
      for (int e = 0; e < NE; e++) if (m_v[e] && m_tag[e] == tg) tgt = e;
      if (tgt < 0) begin
        alloc = 1;
        for (int e = NE - 1; e >= 0; e--) if (!m_v[e]) tgt = e;
        if (tgt < 0) for (int e = 0; e < NE; e++) if (m_age[e] == NE - 1) tgt = e;
      end
      ca = alloc ? 64'd0 : m_acc[tgt];
      ci = alloc ? 64'd0 : m_iss[tgt];
      nm = ca | (64'd1 << a);
      for (int k = 1; k <= MS; k++)
        for (int d = 0; d < 2; d++) begin
          int c, p1, p2;
          c  = (d == 0) ? a + k : a - k;
          p1 = (d == 0) ? a - k : a + k;
          p2 = (d == 0) ? a - 2 * k : a + 2 * k;
          if (np < 2 && c >= 0 && c < 64 && mk(nm, p1) && mk(nm, p2) && !mk(nm, c) && !mk(ci, c)) begin
            pick[np] = c; np++;
          end
        end
      m_v[tgt] = 1; m_tag[tgt] = tg; m_acc[tgt] = nm; m_iss[tgt] = ci;
      for (int e = 0; e < NE; e++) if (e != tgt && m_age[e] < m_age[tgt]) m_age[e]++;
      m_age[tgt] = 0;
    end
    if (pop) begin
      void'(m_q.pop_front());
      if (ph >= 0 && !(acc_valid && alloc && tgt == ph)) m_iss[ph][pl[IW-1:0]] = 1'b1;
    end
    for (int i = 0; i < np; i++)
      if (sz0 + i < DEP) m_q.push_back({acc_line[LAW-1:IW], IW'(pick[i])});
  endtask

  always @(posedge clk) if (rst) model_reset(); else model_step();

  task automatic report(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: cycle-by-cycle comparison of the queue head against the model
  always @(negedge clk)
    if (!rst && !done)
      report(pf_valid === (m_q.size() != 0) && (!pf_valid || pf_line === m_q[0]),
             "R9 stream", {pf_valid, 37'd0, pf_line},
             {(m_q.size() != 0), 37'd0, (m_q.size() != 0) ? m_q[0] : pf_line});

  task automatic expect_head(bit v, logic [LAW-1:0] l, string req);
    report(pf_valid === v && (!v || pf_line === l), req,
           {pf_valid, 37'd0, pf_line}, {v, 37'd0, l});
  endtask

  task automatic access(logic [LAW-1:0] l);
    acc_valid = 1'b1; acc_line = l;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic pop1();
    pf_ready = 1'b1; @(negedge clk); pf_ready = 1'b0;
  endtask

  task automatic drain();
    pf_ready = 1'b1; repeat (6) @(negedge clk); pf_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int pos [12];
    int stp [12];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_head(0, '0, "R1 empty after reset");

    access(ln('h101, 10)); access(ln('h101, 12)); access(ln('h101, 14));
    expect_head(1, ln('h101, 16), "R3 upward stride 2");
    pop1();
    expect_head(0, '0, "R7 accepted request leaves queue");

    access(ln('h102, 40)); access(ln('h102, 38)); access(ln('h102, 36));
    expect_head(1, ln('h102, 34), "R4 downward stride 2");
    drain();

    access(ln('h103, 61)); access(ln('h103, 62)); access(ln('h103, 63));
    expect_head(0, '0, "R5 upper region edge");
    access(ln('h107, 2)); access(ln('h107, 1)); access(ln('h107, 0));
    expect_head(0, '0, "R5 lower region edge");

    access(ln('h104, 0)); access(ln('h104, 2)); access(ln('h104, 6)); access(ln('h104, 4));
    expect_head(0, '0, "R6 accessed line suppressed");

    access(ln('h101, 14));
    expect_head(0, '0, "R7 issued line not requested again");

    pf_ready = 1'b1;
    access(ln('h105, 12)); access(ln('h105, 16)); access(ln('h105, 18));
    access(ln('h105, 19)); access(ln('h105, 23)); access(ln('h105, 26));
    pf_ready = 1'b0;
    drain();
    access(ln('h105, 20));
    expect_head(1, ln('h105, 21), "R8 nearest stride first");
    pop1();
    expect_head(1, ln('h105, 22), "R8 second nearest");
    pop1();
    expect_head(0, '0, "R8 at most two per access");

    access(ln('h106, 0)); access(ln('h106, 1)); access(ln('h106, 2)); access(ln('h106, 4));
    access(ln('h106, 8)); access(ln('h106, 16)); access(ln('h106, 32));
    expect_head(1, ln('h106, 3), "R9 oldest first");
    pop1(); expect_head(1, ln('h106, 6), "R9 order second");
    pop1(); expect_head(1, ln('h106, 12), "R9 order third");
    pop1(); expect_head(1, ln('h106, 24), "R2 line marked while queue held requests");
    pop1(); expect_head(0, '0, "R9 candidate dropped when full");

    do_reset();
    expect_head(0, '0, "R1 queue empty after second reset");
    access(ln('h101, 18));
    expect_head(0, '0, "R1 maps invalidated by reset");

    do_reset();
    access(ln('h200, 0)); access(ln('h200, 2));
    for (int r = 1; r <= 7; r++) access(ln('h200 + r, 0));
    access(ln('h200, 2));
    access(ln('h208, 0));
    access(ln('h200, 4));
    expect_head(1, ln('h200, 6), "R10 recently used region kept");
    drain();

    do_reset();
    access(ln('h200, 0)); access(ln('h200, 2));
    for (int r = 1; r <= 7; r++) access(ln('h200 + r, 0));
    access(ln('h208, 0));
    access(ln('h200, 4));
    expect_head(0, '0, "R10 least recent region evicted");

    do_reset();
    for (int t = 0; t < 12; t++) begin
      pos[t] = int'($urandom % 64);
      stp[t] = int'($urandom % 3) + 1;
      if ($urandom % 2 == 0) stp[t] = -stp[t];
    end
    for (int n = 0; n < 5000; n++) begin
      int t, ix;
      t = int'($urandom % 12);
      if ($urandom % 5 == 0) ix = int'($urandom % 64);
      else begin pos[t] = (pos[t] + stp[t] + 64) % 64; ix = pos[t]; end
      acc_valid = ($urandom % 3 != 0);
      acc_line = ln('h300 + t, ix);
      pf_ready = ($urandom % 2 == 0);
      @(negedge clk);
    end
    acc_valid = 1'b0;
    drain();
    finish_run();
  end
endmodule